// File: doc/BRIEF.md
# SKP Rate-Match Elastic Buffer

This block sits in the receive path of a serial link, between the recovered-clock domain and the local clock domain. It absorbs the small frequency offset between the two clocks. It never stalls the sender. Instead, it adjusts how full it is by dropping or repeating one 32-bit group of skip symbols, and it does so only where the block synchronizer has marked such a group. Ordinary data words pass through unchanged, in order, and exactly once.

On the write side, each arriving word comes with a valid strobe and a skip flag. The write side drops one skip word from an ordered set when its view of the fill level is at or above the almost-full threshold. On the read side, a skip word at the head of the buffer is sent twice when the fill level is at or below the almost-empty threshold. Each ordered set gets at most one deletion and at most one insertion. Read and write pointers cross between the clock domains as Gray codes through two flip-flop stages. Each domain keeps a sticky flag that records a real overflow or underflow that happened despite the correction.

Top module: `skp_elastic_buf`

## Requirements
- R1: After reset, out_valid, overflow and underflow are all 0.
- R2: Every word accepted with skip flag 0 appears on out_data once, in arrival order, with out_skip 0, as long as the buffer is never full.
- R3: A skip word that arrives while the write-side fill is at least AFULL (default 12) is discarded. At most one word is discarded per run of consecutive skip words.
- R4: When the head word is a skip word and the read-side fill is at most AEMPTY (default 4), that word is output twice. This happens at most once per run of consecutive skip words.
- R5: out_skip is 1 exactly for words that entered with in_skip 1, and those words keep their data. For an input set of two skip words, the output run is 1 to 3 words long.
- R6: out_valid stays 0 after reset until at least START (default 8) words have been written.
- R7: A word that arrives while the buffer holds DEPTH (default 16) entries, and that is not a deletion, is lost. It sets overflow, which stays 1 until write-side reset.
- R8: Once reading has started, an empty buffer drives out_valid to 0 and sets underflow, which stays 1 until read-side reset.
- R9: With a write clock within ±300 ppm of the read clock, one two-word skip set every 20 words, and a continuous valid input, neither overflow nor underflow is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Recovered (write) clock |
| wrst_n | input | 1 | Active-low reset, write domain |
| in_data | input | DW | Received word |
| in_valid | input | 1 | in_data holds a word this cycle |
| in_skip | input | 1 | Word is a skip-symbol group of an ordered set |
| overflow | output | 1 | Sticky: a word was lost to a full buffer |
| rclk | input | 1 | Local (read) clock |
| rrst_n | input | 1 | Active-low reset, read domain |
| out_data | output | DW | Output word |
| out_valid | output | 1 | out_data holds a word this cycle |
| out_skip | output | 1 | Output word is a skip-symbol group |
| underflow | output | 1 | Sticky: buffer ran empty after start |

## Verification
The main check is a scoreboard of data words, which must match in order. It runs under four write-clock rates: 300 ppm fast, 300 ppm slow, 2 % fast and 2 % slow. The ppm runs show that normal offset leaves the status flags clear. The 2 % fast run makes the design delete skip words, which shows up as single-word output runs. The 2 % slow run makes it insert skip words, which shows up as three-word runs. A fast run with no skip sets at all shows that only skip words are ever adjusted, because the buffer then has to overflow. A stream that simply stops tells underflow apart from ordinary drain.

// File: rtl/skp_elastic_buf.sv
module skp_elastic_buf #(
  parameter int DW     = 32,
  parameter int AW     = 4,
  parameter int AFULL  = 12,
  parameter int AEMPTY = 4,
  parameter int START  = 8
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  input  logic          in_skip,
  output logic          overflow,
  input  logic          rclk,
  input  logic          rrst_n,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          out_skip,
  output logic          underflow
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW:0] mem [DEPTH];

  // write domain
  logic [PW-1:0] wbin, wgray, rg_s1, rg_s2, wfill, wbin_nxt;
  logic          del_done, del, wr_en, wfull;

  assign wfill    = wbin - g2b(rg_s2);
  assign wfull    = (wfill == PW'(DEPTH));
  assign del      = in_valid && in_skip && !del_done && (wfill >= PW'(AFULL));
  assign wr_en    = in_valid && !del && !wfull;
  assign wbin_nxt = wbin + PW'(wr_en);

  always_ff @(posedge wclk)
    if (wr_en) mem[wbin[AW-1:0]] <= {in_skip, in_data};

  always_ff @(posedge wclk or negedge wrst_n)
    if (!wrst_n) begin
      wbin <= '0; wgray <= '0; rg_s1 <= '0; rg_s2 <= '0;
      del_done <= 1'b0; overflow <= 1'b0;
    end else begin
      wbin  <= wbin_nxt;
      wgray <= wbin_nxt ^ (wbin_nxt >> 1);
      {rg_s2, rg_s1} <= {rg_s1, rgray};
      if (in_valid) del_done <= in_skip && (del_done || del);
      if (in_valid && wfull && !del) overflow <= 1'b1;
    end

  // read domain
  logic [PW-1:0] rbin, rgray, wg_s1, wg_s2, rfill, rbin_nxt;
  logic          primed, ins_done, rempty, go, ins, head_skip;
  logic [DW:0]   head;

  assign rfill     = g2b(wg_s2) - rbin;
  assign rempty    = (rfill == '0);
  assign head      = mem[rbin[AW-1:0]];
  assign head_skip = head[DW];
  assign go        = primed && !rempty;
  assign ins       = go && head_skip && !ins_done && (rfill <= PW'(AEMPTY));
  assign rbin_nxt  = rbin + PW'(go && !ins);

  always_ff @(posedge rclk or negedge rrst_n)
    if (!rrst_n) begin
      rbin <= '0; rgray <= '0; wg_s1 <= '0; wg_s2 <= '0;
      primed <= 1'b0; ins_done <= 1'b0; underflow <= 1'b0;
      out_valid <= 1'b0; out_skip <= 1'b0; out_data <= '0;
    end else begin
      rbin  <= rbin_nxt;
      rgray <= rbin_nxt ^ (rbin_nxt >> 1);
      {wg_s2, wg_s1} <= {wg_s1, wgray};
      if (rfill >= PW'(START)) primed <= 1'b1;
      out_valid <= go;
      if (go) begin
        {out_skip, out_data} <= head;
        ins_done <= head_skip && (ins_done || ins);
      end
      if (primed && rempty) underflow <= 1'b1;
    end

  AST_KEEP_DATA: assert property (@(posedge wclk) disable iff (!wrst_n)
    (in_valid && !in_skip && !wfull) |=> (wbin == $past(wbin) + PW'(1))); // R2
  AST_ONE_DELETE: assert property (@(posedge wclk) disable iff (!wrst_n)
    del |=> !del); // R3
  AST_ONE_INSERT: assert property (@(posedge rclk) disable iff (!rrst_n)
    ins |=> !ins); // R4
  AST_REPEAT_IS_SKIP: assert property (@(posedge rclk) disable iff (!rrst_n)
    (out_valid && rbin == $past(rbin)) |-> out_skip); // R5
  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!wrst_n)
    wfill <= PW'(DEPTH)); // R7
  AST_OVF_STICKY: assert property (@(posedge wclk) disable iff (!wrst_n)
    $past(overflow) |-> overflow); // R7
  AST_UNF_STICKY: assert property (@(posedge rclk) disable iff (!rrst_n)
    $past(underflow) |-> underflow); // R8
  AST_GRAY_STEP: assert property (@(posedge wclk) disable iff (!wrst_n)
    $onehot0(wgray ^ $past(wgray))); // R9
endmodule

// File: tb/tb_skp_elastic_buf.sv
`timescale 1ns/1fs
module tb_skp_elastic_buf;
  localparam logic [31:0] SKPW = 32'h5A5A_5A5A;
  logic wclk = 0, rclk = 0, rst_n = 0;
  logic [31:0] in_data = '0;
  logic in_valid = 0, in_skip = 0;
  logic overflow, underflow, out_valid, out_skip;
  logic [31:0] out_data;
  real whalf = 2.0;
  int errs = 0, checks = 0, run = 0, del_seen = 0, ins_seen = 0, in_words = 0;
  bit cmp_on = 1, seen_first = 0;
  logic [31:0] q[$];

  always #(whalf) wclk = ~wclk;
  always #2.0 rclk = ~rclk;

  skp_elastic_buf dut (.wclk(wclk), .wrst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_skip(in_skip), .overflow(overflow), .rclk(rclk), .rrst_n(rst_n), .out_data(out_data),
    .out_valid(out_valid), .out_skip(out_skip), .underflow(underflow));

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit run_ok(int n);
    return n >= 1 && n <= 3;
  endfunction

  always @(negedge rclk) if (rst_n && out_valid) begin
    if (!seen_first) begin
      seen_first = 1;
      chk(in_words >= 8, "R6", "words written before first output", in_words, 8);
    end
    if (out_skip) begin
      run++;
      if (cmp_on) chk(out_data == SKPW, "R5", "skip word content", out_data, SKPW);
    end else begin
      if (run > 0 && cmp_on) begin
        chk(run_ok(run), "R3/R4", "skip run length", run, 2);
        if (run == 1) del_seen++;
        if (run == 3) ins_seen++;
      end
      run = 0;
      if (cmp_on) begin
        if (q.size() == 0) chk(0, "R2", "unexpected data word", out_data, 0);
        else begin
          logic [31:0] e;
          e = q.pop_front();
          chk(out_data == e, "R2", "data word order", out_data, e);
        end
      end
    end
  end

  task automatic send(logic [31:0] d, bit s);
    @(negedge wclk);
    in_data = d; in_valid = 1; in_skip = s; in_words++;
    if (!s && cmp_on) q.push_back(d);
  endtask

  task automatic stream(int sets, bit with_skp);
    for (int k = 0; k < sets; k++) begin
      for (int i = 0; i < 18; i++) send($urandom, 0);
      if (with_skp) begin send(SKPW, 1); send(SKPW, 1); end
      else begin send($urandom, 0); send($urandom, 0); end
    end
  endtask

  task automatic do_reset();
    @(negedge wclk); in_valid = 0; in_skip = 0;
    rst_n = 0;
    repeat (4) @(posedge rclk);
    q.delete(); run = 0; seen_first = 0; in_words = 0;
    @(negedge rclk); rst_n = 1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge rclk);
    chk(0, "ALL", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int unsigned s;
    s = $urandom(32'd1234);
    do_reset();
    @(negedge rclk);
    chk(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    chk(overflow == 0, "R1", "overflow after reset", overflow, 0);
    chk(underflow == 0, "R1", "underflow after reset", underflow, 0);
    whalf = 1.9994; stream(100, 1);
    whalf = 2.0006; stream(100, 1);
    chk(overflow == 0, "R9", "overflow at 300 ppm", overflow, 0);
    chk(underflow == 0, "R9", "underflow at 300 ppm", underflow, 0);
    del_seen = 0; whalf = 1.96; stream(150, 1);
    chk(del_seen > 0, "R3", "deletions under fast write clock", del_seen, 1);
    chk(overflow == 0, "R3", "overflow under fast write clock", overflow, 0);
    ins_seen = 0; whalf = 2.04; stream(150, 1);
    chk(ins_seen > 0, "R4", "insertions under slow write clock", ins_seen, 1);
    chk(underflow == 0, "R4", "underflow under slow write clock", underflow, 0);
    cmp_on = 0; whalf = 1.96; stream(60, 0);
    chk(overflow == 1, "R7", "overflow without skip sets", overflow, 1);
    chk(underflow == 0, "R7", "no underflow while overfull", underflow, 0);
    whalf = 2.0; do_reset(); cmp_on = 1;
    @(negedge rclk);
    chk(overflow == 0, "R1", "overflow cleared by reset", overflow, 0);
    stream(2, 1);
    @(negedge wclk); in_valid = 0; in_skip = 0;
    repeat (100) @(negedge rclk);
    chk(underflow == 1, "R8", "underflow after input stops", underflow, 1);
    chk(out_valid == 0, "R8", "out_valid once drained", out_valid, 0);
    chk(q.size() == 0, "R2", "words left undelivered", q.size(), 0);
    finish_run();
  end
endmodule